// File: doc/BRIEF.md
# Instruction Fetch Trace Decoder

This block sits on the observing side of a processor bus, for example in trace capture logic. It watches four signals: an active-low instruction-fetch strobe whose pulse width carries the meaning, the active-low address strobe, the active-low data strobe, and a flag that marks show cycles. From these it works out, for every bus cycle, whether the cycle carried an ordinary prefetch, a pipeline flush with the first refill word, or nothing for the instruction stream. Each recognised event produces single-cycle output pulses. Fetches are tracked the same way in every privilege mode, because the block has no privilege input and so cannot filter on it.

A bus cycle is marked by the falling edge of a reference strobe. The reference is the address strobe in normal cycles and the data strobe in show cycles. The fetch strobe is sampled on the first two clocks after that edge and nowhere else. Because of this fixed two-sample window, a strobe that stays low for three clocks across two back-to-back two-clock cycles is read as two separate events: a flush followed by a prefetch.

The block also keeps a small count of the 16-bit words held in a modelled three-entry instruction queue. The count is cleared to one word on a flush and rises by one on each plain fetch until the queue is full. All four inputs pass through synchronizer flops before they are used.

Top module: `ifetch_trace_decoder`

## Requirements
- R1: While reset is applied, and right after it is released, `fetch_pulse` and `flush_pulse` are 0 and `queue_words` is 0.
- R2: With `show_cycle` = 0, a window opens only on a high-to-low transition of `as_n`, and transitions of `ds_n` have no effect.
- R3: With `show_cycle` = 1, a window opens only on a high-to-low transition of `ds_n`, and transitions of `as_n` have no effect.
- R4: In each window `fetch_n` is sampled exactly twice: at the rising edge that first captures the reference strobe low and at the next rising edge. A low `fetch_n` at any other clock is ignored.
- R5: If exactly one of the two samples is low (0), the block asserts `fetch_pulse` alone. This holds whichever of the two samples is the low one.
- R6: If both samples are low, the block asserts `flush_pulse` and `fetch_pulse` together, because a flush always carries the refill word.
- R7: On back-to-back two-clock bus cycles, a `fetch_n` held low for three clocks gives a flush event for the first cycle and then a plain fetch event for the second. The two pulses are two clocks apart.
- R8: A window in which both samples are high (1) produces no pulse.
- R9: Each pulse lasts exactly one clock. With the default two synchronizer stages it is high during the fourth clock period after the rising edge that first captures the reference strobe low.
- R10: `queue_words` becomes 1 one clock after a flush event. It increases by 1 one clock after a plain fetch event, stays at 3 (the queue depth) once it has reached 3, and does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_n | input | 1 | Active-low, pulse-width-coded instruction-fetch strobe |
| as_n | input | 1 | Active-low address strobe, the reference in normal cycles |
| ds_n | input | 1 | Active-low data strobe, the reference in show cycles |
| show_cycle | input | 1 | High during show cycles, selects `ds_n` as the reference |
| fetch_pulse | output | 1 | One-clock pulse: a word entered the instruction queue |
| flush_pulse | output | 1 | One-clock pulse: the queue was flushed (comes with `fetch_pulse`) |
| queue_words | output | 2 | Modelled queue occupancy, 0 to 3 |

## Verification
A corrupted window state shows up as a missing, doubled or wrongly typed pulse, or as a pulse in the wrong clock, at the latest four clocks after the reference edge that should have been recognised. A wrong first-sample flag turns a flush into a fetch, or the reverse, in that same pulse. A bad occupancy value appears on `queue_words` one clock after the next event. After a flush it is overwritten, so the check just after each pulse has to catch it. The scoreboard records when every event is due and what kind it is, and compares each pulse and the occupancy that follows it. Any pulse with no matching expected event is reported as a failure.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  // Sampling window state: waiting for a reference edge, or taking the second sample
  typedef enum logic [0:0] {
    WIN_IDLE   = 1'b0,
    WIN_SECOND = 1'b1
  } win_state_e;

  // Bit order of the synchronized strobe bundle
  localparam int SB_FETCH = 3;
  localparam int SB_AS    = 2;
  localparam int SB_DS    = 1;
  localparam int SB_SHOW  = 0;
  localparam int SB_WIDTH = 4;

endpackage

// File: rtl/ifd_sync.sv
module ifd_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ifd_window.sv
module ifd_window
  import ifd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_n_s,
  input  logic as_n_s,
  input  logic ds_n_s,
  input  logic show_s,
  output logic fetch_pulse,
  output logic flush_pulse
);

  win_state_e state_q, state_d;
  logic       ref_n;
  logic       ref_prev_q;
  logic       ref_fall;
  logic       first_low_q, first_low_d, first_en;
  logic       fetch_q, fetch_d;
  logic       flush_q, flush_d;
  logic       second_low;

  // Reference strobe: data strobe during show cycles, address strobe otherwise
  assign ref_n    = show_s ? ds_n_s : as_n_s;
  assign ref_fall = ref_prev_q & ~ref_n;
  assign second_low = ~fetch_n_s;

  always_comb begin
    state_d     = state_q;
    first_en    = 1'b0;
    first_low_d = first_low_q;
    fetch_d     = 1'b0;
    flush_d     = 1'b0;
    unique case (state_q)
      WIN_IDLE: begin
        if (ref_fall) begin
          first_en    = 1'b1;
          first_low_d = ~fetch_n_s;
          state_d     = WIN_SECOND;
        end
      end
      WIN_SECOND: begin
        fetch_d = first_low_q | second_low;
        flush_d = first_low_q & second_low;
        state_d = WIN_IDLE;
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WIN_IDLE;
      ref_prev_q  <= 1'b1;
      first_low_q <= 1'b0;
      fetch_q     <= 1'b0;
      flush_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_prev_q <= ref_n;
      if (first_en) begin
        first_low_q <= first_low_d;
      end
      fetch_q <= fetch_d;
      flush_q <= flush_d;
    end
  end

  assign fetch_pulse = fetch_q;
  assign flush_pulse = flush_q;

  p_flush_with_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> fetch_pulse);

  p_pulse_single_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pulse |=> !fetch_pulse);

  p_pulse_follows_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pulse |-> $past(state_q == WIN_SECOND));

  p_ref_low_before_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pulse |-> ($past(ref_n, 2) == 1'b0));

endmodule

// File: rtl/ifd_occupancy.sv
module ifd_occupancy #(
  parameter int DEPTH = 3,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_pulse,
  input  logic             flush_pulse,
  output logic [OCC_W-1:0] occ
);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             occ_en;

  assign occ_en = fetch_pulse | flush_pulse;

  always_comb begin
    if (flush_pulse) begin
      occ_d = OCC_W'(1);
    end else if (occ_q < OCC_W'(DEPTH)) begin
      occ_d = occ_q + OCC_W'(1);
    end else begin
      occ_d = occ_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (occ_en) begin
      occ_q <= occ_d;
    end
  end

  assign occ = occ_q;

  p_occ_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  p_flush_refill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> (occ_q == OCC_W'(1)));

  p_fetch_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pulse && !flush_pulse && occ_q < OCC_W'(DEPTH)) |=> (occ_q == $past(occ_q) + OCC_W'(1)));

  p_quiet_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_pulse |=> $stable(occ_q));

endmodule

// File: rtl/ifetch_trace_decoder.sv
module ifetch_trace_decoder
  import ifd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUEUE_DEPTH = 3,
  localparam int OCC_W = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_n,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic             show_cycle,
  output logic             fetch_pulse,
  output logic             flush_pulse,
  output logic [OCC_W-1:0] queue_words
);

  logic                rst_sync_n;
  logic [SB_WIDTH-1:0] strobes_raw;
  logic [SB_WIDTH-1:0] strobes_s;

  // Reset: asserted asynchronously, released through a synchronizer
  ifd_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_sync_n)
  );

  always_comb begin
    strobes_raw           = '0;
    strobes_raw[SB_FETCH] = fetch_n;
    strobes_raw[SB_AS]    = as_n;
    strobes_raw[SB_DS]    = ds_n;
    strobes_raw[SB_SHOW]  = show_cycle;
  end

  // Active-low strobes reset high, the show flag resets low
  ifd_sync #(
    .WIDTH  (SB_WIDTH),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1110)
  ) u_in_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (strobes_raw),
    .q    (strobes_s)
  );

  ifd_window u_window (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fetch_n_s  (strobes_s[SB_FETCH]),
    .as_n_s     (strobes_s[SB_AS]),
    .ds_n_s     (strobes_s[SB_DS]),
    .show_s     (strobes_s[SB_SHOW]),
    .fetch_pulse(fetch_pulse),
    .flush_pulse(flush_pulse)
  );

  ifd_occupancy #(
    .DEPTH(QUEUE_DEPTH)
  ) u_occ (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fetch_pulse(fetch_pulse),
    .flush_pulse(flush_pulse),
    .occ        (queue_words)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |=> (!fetch_pulse && !flush_pulse && queue_words == '0));

endmodule

// File: tb/ifetch_trace_decoder_tb.sv
module ifetch_trace_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       fetch_n, as_n, ds_n, show_cycle;
  logic       fetch_pulse, flush_pulse;
  logic [1:0] queue_words;

  typedef struct {
    int due;
    bit flush;
    int occ;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   model_occ = 0;
  int   pend_occ = -1;
  bit   mon_en = 0;
  bit   done = 0;

  ifetch_trace_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_n    (fetch_n),
    .as_n       (as_n),
    .ds_n       (ds_n),
    .show_cycle (show_cycle),
    .fetch_pulse(fetch_pulse),
    .flush_pulse(flush_pulse),
    .queue_words(queue_words)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fetch_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; show_cycle = 1'b0;
    end
  endtask

  // Drives one bus cycle of n clocks; the reference strobe is low for clocks 0..n-2
  task automatic bus_cycle(int n, bit show, bit f0, bit f1, bit flate);
    bit ref_v, other_v, low;
    exp_t e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_v   = (k < n-1) ? 1'b0 : 1'b1;
      other_v = (n >= 3 && k == 1) ? 1'b0 : 1'b1;
      low     = (k == 0) ? f0 : ((k == 1) ? f1 : flate);
      show_cycle = show;
      fetch_n    = ~low;
      if (show) begin
        ds_n = ref_v; as_n = other_v;
      end else begin
        as_n = ref_v; ds_n = other_v;
      end
      if (k == 0 && (f0 || f1)) begin
        e.due   = cyc + 4;
        e.flush = f0 && f1;
        if (e.flush) model_occ = 1;
        else if (model_occ < 3) model_occ++;
        e.occ = model_occ;
        exp_q.push_back(e);
      end
    end
  endtask

  // Data strobe falls in a normal cycle while the address strobe stays high
  task automatic ds_only();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      show_cycle = 1'b0;
      as_n    = 1'b1;
      ds_n    = (k < 2) ? 1'b0 : 1'b1;
      fetch_n = (k < 2) ? 1'b0 : 1'b1;
    end
  endtask

  // Monitor: pops the scoreboard on each pulse, then checks the following occupancy
  always @(negedge clk) begin
    if (mon_en) begin
      if (pend_occ >= 0) begin
        check(int'(queue_words) == pend_occ, "R10", "queue_words after event", int'(queue_words), pend_occ);
        pend_occ = -1;
      end
      if (fetch_pulse || flush_pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected pulse", int'(flush_pulse) * 2 + int'(fetch_pulse), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.due, "R9", "pulse timing", cyc, e.due);
          check(flush_pulse == e.flush, e.flush ? "R6" : "R5", "flush_pulse", int'(flush_pulse), int'(e.flush));
          check(fetch_pulse == 1'b1, "R6", "fetch_pulse", int'(fetch_pulse), 1);
          pend_occ = e.occ;
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; show_cycle = 1'b0;
    repeat (5) @(negedge clk);
    check(!fetch_pulse && !flush_pulse, "R1", "pulses in reset", int'(fetch_pulse | flush_pulse), 0);
    check(queue_words == 2'd0, "R1", "queue_words in reset", int'(queue_words), 0);
    rst_n = 1'b1;
    idle(6);
    check(!fetch_pulse && !flush_pulse, "R1", "pulses after reset", int'(fetch_pulse | flush_pulse), 0);
    check(queue_words == 2'd0, "R1", "queue_words after reset", int'(queue_words), 0);
    mon_en = 1'b1;

    // R5: single low sample, first or second position, slow bus
    bus_cycle(4, 0, 1, 0, 0);
    bus_cycle(4, 0, 0, 1, 0);
    idle(3);
    // R6: both samples low
    bus_cycle(4, 0, 1, 1, 0);
    idle(2);
    // R10: saturation at three
    bus_cycle(3, 0, 1, 0, 0);
    bus_cycle(3, 0, 1, 0, 0);
    bus_cycle(3, 0, 1, 0, 0);
    idle(6);
    // R8: no low sample
    bus_cycle(3, 0, 0, 0, 0);
    idle(6);
    check(queue_words == 2'd3, "R8", "occupancy after empty window", int'(queue_words), 3);
    // R4: low strobe only outside the window
    bus_cycle(5, 0, 0, 0, 1);
    idle(6);
    check(queue_words == 2'd3, "R4", "occupancy after late strobe", int'(queue_words), 3);
    // R2: data strobe edge in a normal cycle
    ds_only();
    idle(6);
    check(queue_words == 2'd3, "R2", "occupancy after data strobe only", int'(queue_words), 3);
    // R7: three-clock low across back-to-back two-clock cycles
    bus_cycle(2, 0, 1, 1, 0);
    bus_cycle(2, 0, 1, 0, 0);
    bus_cycle(2, 0, 0, 0, 0);
    idle(6);
    // R3: show cycles reference the data strobe
    bus_cycle(3, 1, 1, 1, 0);
    bus_cycle(3, 1, 1, 0, 0);
    idle(10);

    check(exp_q.size() == 0, "R7", "events never seen", exp_q.size(), 0);
    check(queue_words == 2'd2, "R3", "final occupancy", int'(queue_words), 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule